// File: doc/BRIEF.md
# Four-Phase FM Envelope Generator

This block produces the attack, decay, sustain and release loudness curve for every operator slot of an FM synthesizer. It uses one shared datapath that is time-multiplexed across the slots. Each slot stores a 12-bit attenuation and a 2-bit phase. A larger attenuation means a quieter slot, and 0xFFC is silent. The caller picks a slot with `slot` and presents that slot's rate settings, sustain level, key-scale setting and channel keycode. A pulse on `step_en` services that slot once. A pulse on `key_on` or `key_off` starts or releases its note.

A global envelope counter sets the pace of the updates. The counter advances each time the last slot is serviced. For each service, the effective rate of the slot's current phase decides two things: whether the counter value allows an update, and which step size from an 8-entry pattern applies. Attack moves towards zero exponentially. The other phases climb linearly towards silence. There is no streaming data path, so every pin is a plain control or status signal with no handshake. The stored state of the addressed slot is always visible on the outputs.

Top module: `fm_env_gen`

## Requirements
- R1: Phases are encoded attack=0, decay=1, sustain=2, release=3. After reset every slot reads phase 3 and attenuation 0xFFC, and the envelope counter is 0.
- R2: The raw rate is AR in attack, DR in decay, SR in sustain (all 5-bit), and 2*RR+1 in release (RR is 4-bit). A raw rate of 0 gives effective rate 0. Any other raw rate gives min(63, 2*raw + (keycode >> (3-KS))).
- R3: The counter increments by one whenever `step_en` services slot NUM_SLOTS-1. A service changes attenuation only when the low `sh` bits of the counter are zero, where sh = (47-rate)>>2 for rates below 48 and 0 otherwise.
- R4: The step value `inc` is indexed by c = counter bits [sh+2:sh], and p[c] is bit c of a mask. Rates 0 and 1 give 0, and rates 60 and up give 8. Rates 2 to 7 use p[c] with mask 0xEE when rate bits [2:1] are both set, and 0xAA otherwise. Rates 8 to 47 use p[c] with masks 0xAA, 0xBA, 0xEE, 0xFE for rate%4 = 0..3. Rates 48 to 59 use (1+p[c]) << ((rate-48)>>2) with masks 0x00, 0x88, 0xAA, 0xEE.
- R5: In attack, an update lowers attenuation a by 4*ceil((a+1)*inc/64), clamped at 0. If the result is 0, the slot moves to decay.
- R6: In decay, sustain and release, an update adds 4*inc and saturates at 0xFFC. Attenuation is always a multiple of 4 and at most 0xFFC.
- R7: Every service first moves a decay slot to sustain if its attenuation is at least SL*128, or at least 0xFFC when SL=15. The rate is then chosen from the new phase.
- R8: On key-on, if the effective attack rate is 62 or more, the slot becomes decay with attenuation 0. Otherwise it becomes attack with its attenuation unchanged.
- R9: Key-off puts the slot into release with its attenuation unchanged.
- R10: A key-on or key-off in the same cycle as `step_en` replaces the periodic update of that slot. When key-on and key-off coincide, key-on wins. The counter still advances as R3 states.
- R11: `att_out` and `phase_out` show the stored state of the slot selected by `slot`, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Service the addressed slot once |
| key_on | input | 1 | Key-on strobe for the addressed slot |
| key_off | input | 1 | Key-off strobe for the addressed slot |
| slot | input | 5 | Addressed slot index |
| ar | input | 5 | Attack rate of the addressed slot |
| dr | input | 5 | Decay rate of the addressed slot |
| sr | input | 5 | Sustain rate of the addressed slot |
| rr | input | 4 | Release rate field of the addressed slot |
| sl | input | 4 | Sustain level field of the addressed slot |
| ks | input | 2 | Key-scale setting of the addressed slot |
| keycode | input | 5 | Channel keycode for the addressed slot |
| att_out | output | 12 | Stored attenuation of the addressed slot |
| phase_out | output | 2 | Stored phase of the addressed slot |

## Verification
The assertions assume that `slot` always lies below NUM_SLOTS. They also assume that the parameter inputs presented with a strobe belong to the addressed slot, because the block has no storage for them. The stimulus keeps a fixed parameter set for each slot and sweeps the slots in ascending order, so the counter advances exactly as the reference model in the bench expects. Key strobes are issued only on slots whose expected state the model already holds.

// File: rtl/fm_env_pkg.sv
package fm_env_pkg;

  typedef enum logic [1:0] {
    PH_ATTACK  = 2'd0,
    PH_DECAY   = 2'd1,
    PH_SUSTAIN = 2'd2,
    PH_RELEASE = 2'd3
  } env_phase_e;

  localparam int unsigned ATT_W   = 12;
  localparam logic [ATT_W-1:0] ATT_MAX = 12'hFFC;
  localparam logic [5:0] INSTANT_RATE = 6'd62;

  // step size for a given effective rate and 3-bit step index
  function automatic logic [3:0] step_inc(input logic [5:0] rate, input logic [2:0] cyc);
    logic [7:0] pat;
    logic [3:0] base;
    logic [5:0] over;
    if (rate < 6'd2) return 4'd0;
    if (rate >= 6'd60) return 4'd8;
    if (rate < 6'd48) begin
      if (rate < 6'd8) begin
        pat = (rate[2:1] == 2'b11) ? 8'hEE : 8'hAA;
      end else begin
        case (rate[1:0])
          2'd0:    pat = 8'hAA;
          2'd1:    pat = 8'hBA;
          2'd2:    pat = 8'hEE;
          default: pat = 8'hFE;
        endcase
      end
      return {3'b000, pat[cyc]};
    end
    case (rate[1:0])
      2'd0:    pat = 8'h00;
      2'd1:    pat = 8'h88;
      2'd2:    pat = 8'hAA;
      default: pat = 8'hEE;
    endcase
    base = 4'd1 + {3'b000, pat[cyc]};
    over = rate - 6'd48;
    return base << over[3:2];
  endfunction

endpackage

// File: rtl/fm_env_rate.sv
module fm_env_rate (
  input  logic [4:0] raw,
  input  logic [1:0] ks,
  input  logic [4:0] keycode,
  output logic [5:0] eff
);
  logic [4:0] kadd;
  logic [6:0] sum;

  always_comb begin
    kadd = keycode >> (2'd3 - ks);
    sum  = {1'b0, raw, 1'b0} + {2'b00, kadd};
    if (raw == 5'd0)        eff = 6'd0;
    else if (sum > 7'd63)   eff = 6'd63;
    else                    eff = sum[5:0];
  end
endmodule

// File: rtl/fm_env_step.sv
module fm_env_step #(
  parameter int unsigned CNT_W = 15
) (
  input  logic [5:0]       rate,
  input  logic [CNT_W-1:0] cnt,
  output logic             due,
  output logic [3:0]       inc
);
  import fm_env_pkg::*;

  logic [5:0]       diff;
  logic [3:0]       sh;
  logic [CNT_W-1:0] mask;
  logic [2:0]       cyc;

  always_comb begin
    diff = 6'd47 - rate;
    sh   = (rate < 6'd48) ? diff[5:2] : 4'd0;
    mask = (CNT_W'(1) << sh) - CNT_W'(1);
    due  = ((cnt & mask) == '0);
    cyc  = 3'(cnt >> sh);
    inc  = step_inc(rate, cyc);
  end
endmodule

// File: rtl/fm_env_next.sv
module fm_env_next (
  input  logic [11:0]            att,
  input  fm_env_pkg::env_phase_e phase,
  input  logic                   due,
  input  logic [3:0]             inc,
  output logic [11:0]            att_nx,
  output fm_env_pkg::env_phase_e phase_nx
);
  import fm_env_pkg::*;

  logic [16:0] prod;
  logic [16:0] prod_r;
  logic [11:0] fall;
  logic [12:0] rise;

  always_comb begin
    prod   = 17'(({5'b0, att} + 17'd1) * {13'b0, inc});
    prod_r = prod + 17'd63;
    fall   = 12'((prod_r >> 6) << 2);
    rise   = {1'b0, att} + 13'({inc, 2'b00});
    att_nx   = att;
    phase_nx = phase;
    if (due) begin
      if (phase == PH_ATTACK) begin
        att_nx = (att < fall) ? 12'd0 : att - fall;
        if (att_nx == 12'd0) phase_nx = PH_DECAY;
      end else begin
        att_nx = (rise > {1'b0, ATT_MAX}) ? ATT_MAX : rise[11:0];
      end
    end
  end
endmodule

// File: rtl/fm_env_gen.sv
module fm_env_gen #(
  parameter int unsigned NUM_SLOTS = 24,
  parameter int unsigned CNT_W     = 15,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              key_on,
  input  logic              key_off,
  input  logic [SLOT_W-1:0] slot,
  input  logic [4:0]        ar,
  input  logic [4:0]        dr,
  input  logic [4:0]        sr,
  input  logic [3:0]        rr,
  input  logic [3:0]        sl,
  input  logic [1:0]        ks,
  input  logic [4:0]        keycode,
  output logic [11:0]       att_out,
  output logic [1:0]        phase_out
);
  import fm_env_pkg::*;

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  logic [11:0]  att_mem [NUM_SLOTS];
  env_phase_e   ph_mem  [NUM_SLOTS];
  logic [CNT_W-1:0] cnt;

  logic [11:0]  cur_att;
  env_phase_e   cur_ph;
  env_phase_e   ph_eff;
  logic [11:0]  sus_lvl;
  logic [4:0]   raw_sel;
  logic [5:0]   eff_rate;
  logic [5:0]   atk_rate;
  logic         due;
  logic [3:0]   inc;
  logic [11:0]  att_nx;
  env_phase_e   ph_nx;

  assign cur_att   = att_mem[slot];
  assign cur_ph    = ph_mem[slot];
  assign att_out   = cur_att;
  assign phase_out = cur_ph;

  // sustain entry is checked before the rate is chosen
  always_comb begin
    sus_lvl = (sl == 4'hF) ? ATT_MAX : {1'b0, sl, 7'b0};
    ph_eff  = (cur_ph == PH_DECAY && cur_att >= sus_lvl) ? PH_SUSTAIN : cur_ph;
    case (ph_eff)
      PH_ATTACK:  raw_sel = ar;
      PH_DECAY:   raw_sel = dr;
      PH_SUSTAIN: raw_sel = sr;
      default:    raw_sel = {rr, 1'b1};
    endcase
  end

  fm_env_rate u_rate (.raw(raw_sel), .ks(ks), .keycode(keycode), .eff(eff_rate));
  fm_env_rate u_atk_rate (.raw(ar), .ks(ks), .keycode(keycode), .eff(atk_rate));

  fm_env_step #(.CNT_W(CNT_W)) u_step (
    .rate(eff_rate), .cnt(cnt), .due(due), .inc(inc)
  );

  fm_env_next u_next (
    .att(cur_att), .phase(ph_eff), .due(due), .inc(inc),
    .att_nx(att_nx), .phase_nx(ph_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        att_mem[i] <= ATT_MAX;
        ph_mem[i]  <= PH_RELEASE;
      end
    end else if (key_on) begin
      if (atk_rate >= INSTANT_RATE) begin
        att_mem[slot] <= 12'd0;
        ph_mem[slot]  <= PH_DECAY;
      end else begin
        ph_mem[slot]  <= PH_ATTACK;
      end
    end else if (key_off) begin
      ph_mem[slot] <= PH_RELEASE;
    end else if (step_en) begin
      att_mem[slot] <= att_nx;
      ph_mem[slot]  <= ph_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                            cnt <= '0;
    else if (step_en && slot == LAST_SLOT) cnt <= cnt + CNT_W'(1);
  end

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (att_out == ATT_MAX && phase_out == 2'd3));

  p_att_grid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (att_out[1:0] == 2'b00 && att_out <= ATT_MAX));

  p_zero_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && eff_rate == 6'd0) |-> inc == 4'd0);

  p_hold_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !key_on && !key_off && !due) |=> att_mem[$past(slot)] == $past(att_out));

  p_attack_falls_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !key_on && !key_off && cur_ph == PH_ATTACK)
      |=> att_mem[$past(slot)] <= $past(att_out));

  p_instant_attack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (key_on && atk_rate >= INSTANT_RATE)
      |=> (att_mem[$past(slot)] == 12'd0 && ph_mem[$past(slot)] == PH_DECAY));

  p_keyoff_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (key_off && !key_on)
      |=> (ph_mem[$past(slot)] == PH_RELEASE && att_mem[$past(slot)] == $past(att_out)));

  p_key_over_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (key_on && step_en && atk_rate < INSTANT_RATE)
      |=> (ph_mem[$past(slot)] == PH_ATTACK && att_mem[$past(slot)] == $past(att_out)));

endmodule

// File: tb/tb_fm_env_gen.sv
module tb_fm_env_gen;
  localparam int NS = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_en = 1'b0, key_on = 1'b0, key_off = 1'b0;
  logic [4:0] slot = '0, ar = '0, dr = '0, sr = '0, keycode = '0;
  logic [3:0] rr = '0, sl = '0;
  logic [1:0] ks = '0;
  logic [11:0] att_out;
  logic [1:0]  phase_out;

  always #4 clk = ~clk;

  fm_env_gen dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .key_on(key_on), .key_off(key_off),
    .slot(slot), .ar(ar), .dr(dr), .sr(sr), .rr(rr), .sl(sl), .ks(ks),
    .keycode(keycode), .att_out(att_out), .phase_out(phase_out)
  );

  int n_chk = 0, n_fail = 0;
  int p_ar[NS], p_dr[NS], p_sr[NS], p_rr[NS], p_sl[NS], p_ks[NS], p_kc[NS];
  int m_att[NS], m_ph[NS];
  int m_cnt = 0;

  // {ar, ks, keycode, expected phase after key-on}
  localparam logic [13:0] KON_TAB [6] = '{
    {5'd31, 2'd0, 5'd0,  2'd1},
    {5'd30, 2'd3, 5'd2,  2'd1},
    {5'd30, 2'd0, 5'd31, 2'd1},
    {5'd30, 2'd2, 5'd3,  2'd0},
    {5'd0,  2'd3, 5'd31, 2'd0},
    {5'd15, 2'd3, 5'd31, 2'd0}
  };

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int m_eff(input int raw, input int k, input int kc);
    int v;
    if (raw == 0) return 0;
    v = 2 * raw + (kc >> (3 - k));
    return (v > 63) ? 63 : v;
  endfunction

  function automatic int m_inc(input int r, input int c);
    int lo[4] = '{8'hAA, 8'hBA, 8'hEE, 8'hFE};
    int hi[4] = '{8'h00, 8'h88, 8'hAA, 8'hEE};
    int pat;
    if (r < 2) return 0;
    if (r >= 60) return 8;
    if (r < 8) begin
      pat = ((r & 6) == 6) ? 8'hEE : 8'hAA;
      return (pat >> c) & 1;
    end
    if (r < 48) return (lo[r % 4] >> c) & 1;
    return (1 + ((hi[r % 4] >> c) & 1)) << ((r - 48) / 4);
  endfunction

  task automatic m_service(input int s);
    int sll, raw, r, sh, inc, p, d;
    sll = (p_sl[s] == 15) ? 4092 : p_sl[s] * 128;
    if (m_ph[s] == 1 && m_att[s] >= sll) m_ph[s] = 2;
    case (m_ph[s])
      0: raw = p_ar[s];
      1: raw = p_dr[s];
      2: raw = p_sr[s];
      default: raw = p_rr[s] * 2 + 1;
    endcase
    r  = m_eff(raw, p_ks[s], p_kc[s]);
    sh = (r < 48) ? (47 - r) / 4 : 0;
    if ((m_cnt % (1 << sh)) == 0) begin
      inc = m_inc(r, (m_cnt >> sh) & 7);
      if (m_ph[s] == 0) begin
        p = (m_att[s] + 1) * inc;
        d = 4 * ((p + 63) / 64);
        m_att[s] = (d > m_att[s]) ? 0 : m_att[s] - d;
        if (m_att[s] == 0) m_ph[s] = 1;
      end else begin
        m_att[s] = m_att[s] + 4 * inc;
        if (m_att[s] > 4092) m_att[s] = 4092;
      end
    end
  endtask

  task automatic svc(input int s, input bit st, input bit kon, input bit koff);
    @(negedge clk);
    slot = 5'(s); ar = 5'(p_ar[s]); dr = 5'(p_dr[s]); sr = 5'(p_sr[s]);
    rr = 4'(p_rr[s]); sl = 4'(p_sl[s]); ks = 2'(p_ks[s]); keycode = 5'(p_kc[s]);
    step_en = st; key_on = kon; key_off = koff;
    @(posedge clk);
    #1;
    step_en = 1'b0; key_on = 1'b0; key_off = 1'b0;
    if (kon) begin
      if (m_eff(p_ar[s], p_ks[s], p_kc[s]) >= 62) begin m_ph[s] = 1; m_att[s] = 0; end
      else m_ph[s] = 0;
    end else if (koff) begin
      m_ph[s] = 3;
    end else if (st) begin
      m_service(s);
    end
    if (st && s == NS - 1) m_cnt = (m_cnt + 1) % 32768;
  endtask

  task automatic frames(input int n);
    for (int f = 0; f < n; f++) begin
      for (int s = 0; s < NS; s++) begin
        svc(s, 1'b1, 1'b0, 1'b0);
        chk("R3 R4 R5 R6 R7 att", int'(att_out), m_att[s]);
        chk("R3 R5 R7 phase", int'(phase_out), m_ph[s]);
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      p_ar[s] = 0; p_dr[s] = 0; p_sr[s] = 0; p_rr[s] = 0;
      p_sl[s] = 0; p_ks[s] = 0; p_kc[s] = 0;
      m_att[s] = 4092; m_ph[s] = 3;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 / R11: reset state read through the addressed-slot outputs
    for (int s = 0; s < NS; s++) begin
      svc(s, 1'b0, 1'b0, 1'b0);
      chk("R1 R11 reset att", int'(att_out), 4092);
      chk("R1 reset phase", int'(phase_out), 3);
    end

    // R8 / R2: key-on table on slots 2..7
    for (int i = 0; i < 6; i++) begin
      p_ar[i+2] = int'(KON_TAB[i][13:9]);
      p_ks[i+2] = int'(KON_TAB[i][8:7]);
      p_kc[i+2] = int'(KON_TAB[i][6:2]);
      svc(i + 2, 1'b0, 1'b1, 1'b0);
      chk("R8 R2 key-on phase", int'(phase_out), int'(KON_TAB[i][1:0]));
      chk("R8 key-on att", int'(att_out), (KON_TAB[i][1:0] == 2'd1) ? 0 : 4092);
    end

    // envelope runs on slot 0 (slow attack) and slot 1 (instant attack, SL=15)
    p_ar[0] = 20; p_dr[0] = 28; p_sr[0] = 20; p_sl[0] = 2; p_rr[0] = 15;
    p_ar[1] = 31; p_dr[1] = 28; p_sr[1] = 0;  p_sl[1] = 15; p_rr[1] = 2;
    p_ks[1] = 1;  p_kc[1] = 20;
    svc(0, 1'b0, 1'b1, 1'b0);
    chk("R8 slow attack phase", int'(phase_out), 0);
    svc(1, 1'b0, 1'b1, 1'b0);
    chk("R8 instant attack att", int'(att_out), 0);
    frames(200);
    chk("R7 SL15 boundary phase", m_ph[1], 2);

    svc(0, 1'b0, 1'b0, 1'b1);
    chk("R9 key-off phase", int'(phase_out), 3);
    chk("R9 key-off att", int'(att_out), m_att[0]);
    frames(150);
    chk("R6 release saturates", m_att[0], 4092);

    // R10: key-on with step in the same cycle, attack not instant
    p_ar[4] = 0;
    svc(4, 1'b1, 1'b1, 1'b0);
    chk("R10 key-on over step phase", int'(phase_out), 0);
    chk("R10 key-on over step att", int'(att_out), 0);

    // R10: key-on and key-off together, key-on wins
    p_ar[8] = 31;
    svc(8, 1'b1, 1'b1, 1'b1);
    chk("R10 both keys phase", int'(phase_out), 1);
    chk("R10 both keys att", int'(att_out), 0);

    // R9 / R10: key-off with step on slot 1, attenuation kept
    begin
      int prev;
      prev = m_att[1];
      svc(1, 1'b1, 1'b0, 1'b1);
      chk("R9 R10 key-off over step phase", int'(phase_out), 3);
      chk("R9 R10 key-off over step att", int'(att_out), prev);
    end

    frames(20);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule